// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port

This block is a serial test access port in the IEEE 1149.1 style. It is clocked by the test clock and steered by the mode-select line. It runs the sixteen-state controller, a three-bit instruction register and three data registers. The data registers are a one-bit bypass stage, a 32-bit identification register and a boundary register that takes a snapshot of the device pins. A board tester uses the port to read the identification code, to shorten the scan chain through the bypass stage, and to sample the pin ring. It can also tell the functional core to float its outputs.

The port has no dedicated reset pin. The controller is reset either by the power-on reset or by holding mode-select high for five test-clock edges, and neither path touches functional logic. The boundary register only observes the pins. Update-DR never drives them. The all-zeros opcode and the high-impedance sample opcode both sample the pins and raise a float request toward the core. TDO and its enable change on the falling edge of the test clock.

Top module: `tap_lite`

## Requirements
- R1: While por_n is low, the controller sits in Test-Logic-Reset, the current instruction is IDCODE (3'b001), tdo_en is low and core_hiz is low; the first data scan after power-up returns the identification code.
- R2: From any state, five consecutive rising TCK edges with TMS high reach Test-Logic-Reset. On the first rising edge spent there, the current instruction becomes IDCODE and core_hiz drops.
- R3: Capture-IR loads 3'b001 into the instruction shift stage, so the two least significant bits read 1 then 0 on TDO.
- R4: A shifted opcode becomes the current instruction only on the rising edge that leaves Update-IR. Until then core_hiz and the selected data register keep their previous values, including in Pause-IR.
- R5: TDI enters the most significant bit of the selected register and TDO presents its least significant bit, so bit 0 comes out first. TDO changes only on the falling edge of TCK.
- R6: tdo_en is high after a falling edge in Shift-DR or Shift-IR and low in every other state.
- R7: The IDCODE opcode 001 selects a 32-bit register that captures the ID_CODE parameter. Bit 0 of that parameter must be 1, and this is enforced at elaboration.
- R8: BYPASS 111 and the reserved opcodes 011, 101 and 110 select the one-bit bypass register. It captures 0 and delays TDI by one shift.
- R9: SAMPLE 100, EXTEST 000 and SAMPLE-Z 010 select the BSR_LEN-bit boundary register. In Capture-DR, bit i of that register loads pins_in[i]. Update-DR changes nothing, so data shifted in never reaches a later capture.
- R10: core_hiz is high exactly while the current instruction is EXTEST 000 or SAMPLE-Z 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge of tck |
| tdi | input | 1 | Serial data in, sampled on the rising edge of tck |
| pins_in | input | BSR_LEN | Current levels of the observed device pins |
| tdo | output | 1 | Serial data out, updated on the falling edge of tck |
| tdo_en | output | 1 | High while tdo carries shift data |
| core_hiz | output | 1 | Request for the functional core to float its outputs |

## Verification
The hardest case to reach from the ports is the TMS-only reset starting from an arbitrary controller state, including mid-shift, the pause states and just after a stray Update-IR. The stimulus first loads BYPASS. It then walks the controller along many arithmetically generated TMS paths of different lengths, applies five ones, and expects the full identification code on the next data scan. The second hard case is the opcode decode. All eight opcodes are swept, and for each one a stream of ones is pushed through while the pins are held low. The length of the leading captured run then tells which register was selected, without any view of internal state.

// File: rtl/tap_lite_pkg.sv
package tap_lite_pkg;

   typedef enum logic [3:0] {
      S_RESET  = 4'd0,
      S_IDLE   = 4'd1,
      S_SEL_DR = 4'd2,
      S_CAP_DR = 4'd3,
      S_SHF_DR = 4'd4,
      S_EX1_DR = 4'd5,
      S_PAU_DR = 4'd6,
      S_EX2_DR = 4'd7,
      S_UPD_DR = 4'd8,
      S_SEL_IR = 4'd9,
      S_CAP_IR = 4'd10,
      S_SHF_IR = 4'd11,
      S_EX1_IR = 4'd12,
      S_PAU_IR = 4'd13,
      S_EX2_IR = 4'd14,
      S_UPD_IR = 4'd15
   } tap_state_e;

   localparam int IR_W = 3;

   localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
   localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
   localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
   localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
   localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

   localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

   typedef enum logic [1:0] {
      DR_BYP = 2'd0,
      DR_ID  = 2'd1,
      DR_BSR = 2'd2
   } dr_sel_e;

   function automatic dr_sel_e pick_dr(input logic [IR_W-1:0] op);
      case (op)
         OP_IDCODE:                       pick_dr = DR_ID;
         OP_EXTEST, OP_SAMPZ, OP_SAMPLE:  pick_dr = DR_BSR;
         default:                         pick_dr = DR_BYP;
      endcase
   endfunction

   function automatic logic wants_hiz(input logic [IR_W-1:0] op);
      wants_hiz = (op == OP_EXTEST) || (op == OP_SAMPZ);
   endfunction

endpackage

// File: rtl/tap_lite_fsm.sv
module tap_lite_fsm
   import tap_lite_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         S_RESET:  nxt = tms ? S_RESET  : S_IDLE;
         S_IDLE:   nxt = tms ? S_SEL_DR : S_IDLE;
         S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
         S_CAP_DR: nxt = tms ? S_EX1_DR : S_SHF_DR;
         S_SHF_DR: nxt = tms ? S_EX1_DR : S_SHF_DR;
         S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
         S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
         S_EX2_DR: nxt = tms ? S_UPD_DR : S_SHF_DR;
         S_UPD_DR: nxt = tms ? S_SEL_DR : S_IDLE;
         S_SEL_IR: nxt = tms ? S_RESET  : S_CAP_IR;
         S_CAP_IR: nxt = tms ? S_EX1_IR : S_SHF_IR;
         S_SHF_IR: nxt = tms ? S_EX1_IR : S_SHF_IR;
         S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
         S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
         S_EX2_IR: nxt = tms ? S_UPD_IR : S_SHF_IR;
         S_UPD_IR: nxt = tms ? S_SEL_DR : S_IDLE;
         default:  nxt = S_RESET;
      endcase
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= S_RESET;
      else        state <= nxt;
   end

   // run length of sampled TMS ones, saturating at four, for the R2 check
   logic [2:0] ones_run;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)            ones_run <= 3'd0;
      else if (!tms)         ones_run <= 3'd0;
      else if (ones_run < 4) ones_run <= ones_run + 3'd1;
   end

   // R2: the fifth consecutive high TMS lands in Test-Logic-Reset
   a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
      (ones_run == 3'd4 && tms) |=> (state == S_RESET));

endmodule

// File: rtl/tap_lite_ir.sv
module tap_lite_ir
   import tap_lite_pkg::*;
(
   input  logic            tck,
   input  logic            por_n,
   input  logic            tdi,
   input  tap_state_e      state,
   output logic            ir_lsb,
   output logic [IR_W-1:0] cur_op
);

   logic [IR_W-1:0] ir_sr;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         ir_sr <= IR_CAPTURE;
      end else begin
         case (state)
            S_CAP_IR: ir_sr <= IR_CAPTURE;
            S_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            default:  ir_sr <= ir_sr;
         endcase
      end
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                   cur_op <= OP_IDCODE;
      else if (state == S_RESET)    cur_op <= OP_IDCODE;
      else if (state == S_UPD_IR)   cur_op <= ir_sr;
   end

   assign ir_lsb = ir_sr[0];

   // R3: capture pattern in the instruction shift stage
   a_r3_capture_ir_pattern: assert property (@(posedge tck) disable iff (!por_n)
      (state == S_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

   // R4: current instruction moves only out of Update-IR or Test-Logic-Reset
   a_r4_ir_update_only: assert property (@(posedge tck) disable iff (!por_n)
      !$stable(cur_op) |-> ($past(state) == S_UPD_IR || $past(state) == S_RESET));

endmodule

// File: rtl/tap_lite_dr.sv
module tap_lite_dr
   import tap_lite_pkg::*;
#(
   parameter int           BSR_LEN = 70,
   parameter logic [31:0]  ID_CODE = 32'h5EB1_C0DB
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tdi,
   input  tap_state_e         state,
   input  dr_sel_e            sel,
   input  logic [BSR_LEN-1:0] pins_in,
   output logic               dr_lsb
);

   localparam int ID_W = 32;

   if (ID_CODE[0] != 1'b1) begin : g_bad_id
      $error("tap_lite_dr: ID_CODE bit 0 must be 1");
   end
   if (BSR_LEN < 2) begin : g_bad_len
      $error("tap_lite_dr: BSR_LEN must be at least 2");
   end

   logic               byp_q;
   logic [ID_W-1:0]    id_sr;
   logic [BSR_LEN-1:0] bsr_sr;

   logic cap, shf;
   assign cap = (state == S_CAP_DR);
   assign shf = (state == S_SHF_DR);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                         byp_q <= 1'b0;
      else if (sel == DR_BYP && cap)      byp_q <= 1'b0;
      else if (sel == DR_BYP && shf)      byp_q <= tdi;
   end

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                         id_sr <= ID_CODE;
      else if (sel == DR_ID && cap)       id_sr <= ID_CODE;
      else if (sel == DR_ID && shf)       id_sr <= {tdi, id_sr[ID_W-1:1]};
   end

   // boundary cells: each one either samples its pin or takes its upper neighbour
   for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
      logic from_up;
      if (i == BSR_LEN - 1) begin : g_top
         assign from_up = tdi;
      end else begin : g_mid
         assign from_up = bsr_sr[i+1];
      end
      always_ff @(posedge tck or negedge por_n) begin
         if (!por_n)                      bsr_sr[i] <= 1'b0;
         else if (sel == DR_BSR && cap)   bsr_sr[i] <= pins_in[i];
         else if (sel == DR_BSR && shf)   bsr_sr[i] <= from_up;
      end
   end

   always_comb begin
      case (sel)
         DR_ID:   dr_lsb = id_sr[0];
         DR_BSR:  dr_lsb = bsr_sr[0];
         default: dr_lsb = byp_q;
      endcase
   end

   // R8: bypass stage captures zero
   a_r8_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
      (cap && sel == DR_BYP) |=> (byp_q == 1'b0));

   // R9: boundary capture mirrors the pins seen at the capture edge
   a_r9_bsr_capture: assert property (@(posedge tck) disable iff (!por_n)
      (cap && sel == DR_BSR) |=> (bsr_sr == $past(pins_in)));

   // R7: identification capture yields the parameter value
   a_r7_id_capture: assert property (@(posedge tck) disable iff (!por_n)
      (cap && sel == DR_ID) |=> (id_sr == ID_CODE));

endmodule

// File: rtl/tap_lite.sv
module tap_lite
   import tap_lite_pkg::*;
#(
   parameter int          BSR_LEN = 70,
   parameter logic [31:0] ID_CODE = 32'h5EB1_C0DB
) (
   input  logic               tck,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pins_in,
   output logic               tdo,
   output logic               tdo_en,
   output logic               core_hiz
);

   tap_state_e      state;
   logic            ir_lsb;
   logic            dr_lsb;
   logic [IR_W-1:0] cur_op;
   dr_sel_e         sel;

   tap_lite_fsm u_fsm (
      .tck   (tck),
      .por_n (por_n),
      .tms   (tms),
      .state (state)
   );

   tap_lite_ir u_ir (
      .tck    (tck),
      .por_n  (por_n),
      .tdi    (tdi),
      .state  (state),
      .ir_lsb (ir_lsb),
      .cur_op (cur_op)
   );

   assign sel      = pick_dr(cur_op);
   assign core_hiz = wants_hiz(cur_op);

   tap_lite_dr #(
      .BSR_LEN (BSR_LEN),
      .ID_CODE (ID_CODE)
   ) u_dr (
      .tck     (tck),
      .por_n   (por_n),
      .tdi     (tdi),
      .state   (state),
      .sel     (sel),
      .pins_in (pins_in),
      .dr_lsb  (dr_lsb)
   );

   // output stage on the falling edge of the test clock
   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= (state == S_SHF_DR) || (state == S_SHF_IR);
         tdo    <= (state == S_SHF_IR) ? ir_lsb : dr_lsb;
      end
   end

   // R6: enable only ever seen in a shift state
   a_r6_tdo_en_shift: assert property (@(posedge tck) disable iff (!por_n)
      tdo_en |-> (state == S_SHF_DR || state == S_SHF_IR));

   // R10: float request rises only as an instruction is committed
   a_r10_hiz_on_update: assert property (@(posedge tck) disable iff (!por_n)
      $rose(core_hiz) |-> ($past(state) == S_UPD_IR));

endmodule

// File: tb/tb_tap_lite.sv
module tb_tap_lite;

   localparam int          N  = 70;
   localparam logic [31:0] ID = 32'h5EB1_C0DB;

   logic         tck = 1'b0;
   logic         por_n = 1'b0;
   logic         tms = 1'b1;
   logic         tdi = 1'b0;
   logic [N-1:0] pins_in = '0;
   logic         tdo, tdo_en, core_hiz;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 tck = ~tck;

   tap_lite #(.BSR_LEN(N), .ID_CODE(ID)) dut (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pins_in(pins_in),
      .tdo(tdo), .tdo_en(tdo_en), .core_hiz(core_hiz)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one test-clock cycle: mid = tdo just after the rising edge, o/oe after the falling edge
   task automatic step(input logic m, input logic d, output logic mid, output logic o, output logic oe);
      tms = m;
      tdi = d;
      @(posedge tck); #1;
      mid = tdo;
      @(negedge tck); #1;
      o = tdo;
      oe = tdo_en;
   endtask

   task automatic go(input logic m);
      logic a, b, c;
      step(m, 1'b0, a, b, c);
   endtask

   task automatic tms_reset();
      for (int i = 0; i < 5; i++) go(1'b1);
      go(1'b0);
   endtask

   // from Run-Test/Idle; optional stop in Pause-IR to observe R4
   task automatic load_ir(input logic [2:0] op, input bit pause_check, output logic [2:0] cap);
      logic a, o, oe;
      logic hiz_before;
      hiz_before = core_hiz;
      go(1'b1); go(1'b1); go(1'b0);
      step(1'b0, 1'b0, a, o, oe);
      cap[0] = o;
      for (int i = 0; i < 3; i++) begin
         step(i == 2, op[i], a, o, oe);
         if (i < 2) cap[i+1] = o;
      end
      if (pause_check) begin
         go(1'b0);
         chk("R4 pause-ir holds core_hiz", core_hiz, hiz_before);
         chk("R6 tdo_en low in pause-ir", tdo_en, 1'b0);
         go(1'b1);
      end
      go(1'b1);
      if (pause_check) chk("R4 update-ir state holds core_hiz", core_hiz, hiz_before);
      go(1'b0);
   endtask

   task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
      logic mid, o, oe, prev;
      dout = '0;
      go(1'b1); go(1'b0);
      step(1'b0, 1'b0, mid, o, oe);
      dout[0] = o;
      prev = o;
      chk("R6 tdo_en high in shift-dr", oe, 1'b1);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], mid, o, oe);
         if (i == 0) chk("R5 tdo steady across rising edge", mid, prev);
         if (i < n - 1) dout[i+1] = o;
         prev = o;
      end
      chk("R6 tdo_en low in exit1-dr", oe, 1'b0);
      go(1'b1); go(1'b0);
   endtask

   function automatic logic [127:0] pin_pattern(input int k);
      logic [127:0] p;
      p = '0;
      for (int b = 0; b < N; b++) p[b] = (((b * (k + 3)) + k) % 3) == 0;
      return p;
   endfunction

   initial begin
      logic [127:0] dout, expv, ones;
      logic [2:0] cap;
      #13;
      chk("R1 tdo_en low at power-up", tdo_en, 1'b0);
      chk("R1 core_hiz low at power-up", core_hiz, 1'b0);
      por_n = 1'b1;
      go(1'b0);
      scan_dr(32, '0, dout);
      chk("R1 R7 first scan gives id code", dout[31:0], ID);
      chk("R7 id bit 0 is one", dout[0], 1'b1);

      // R3 and R4 with a pause stop, loading SAMPLE-Z
      load_ir(3'b010, 1'b1, cap);
      chk("R3 capture-ir bits 1:0", cap[1:0], 2'b01);
      chk("R4 R10 core_hiz after update of sample-z", core_hiz, 1'b1);

      // R8 bypass: one-stage delay, capture 0 (R5 ordering)
      load_ir(3'b111, 1'b0, cap);
      chk("R10 core_hiz low under bypass", core_hiz, 1'b0);
      scan_dr(16, 128'hB4E1, dout);
      chk("R8 R5 bypass delays tdi by one", dout[16:0], {128'hB4E1, 1'b0} & 128'hFFFF);

      // R9 sample sweeps; shifted data never reaches a later capture
      load_ir(3'b100, 1'b0, cap);
      for (int k = 0; k < 6; k++) begin
         pins_in = pin_pattern(k)[N-1:0];
         scan_dr(N, ~pin_pattern(k), dout);
         chk("R9 boundary capture equals pins", dout[N-1:0], pin_pattern(k)[N-1:0]);
      end

      // R8 R9 R10 R7: exhaustive opcode sweep, pins low, tdi all ones
      pins_in = '0;
      ones = '1;
      for (int op = 0; op < 8; op++) begin
         load_ir(op[2:0], 1'b0, cap);
         chk("R3 capture-ir bits 1:0 on sweep", cap[1:0], 2'b01);
         chk("R10 core_hiz per opcode", core_hiz, (op == 0 || op == 2));
         scan_dr(100, ones, dout);
         expv = '1;
         if (op == 0 || op == 2 || op == 4) begin
            for (int b = 0; b < N; b++) expv[b] = 1'b0;
         end else if (op == 1) begin
            for (int b = 0; b < 32; b++) expv[b] = ID[b];
         end else begin
            expv[0] = 1'b0;
         end
         chk("R7 R8 R9 selected register per opcode", dout[99:0], expv[99:0]);
      end

      // R2: arbitrary TMS walks, then five ones
      for (int k = 1; k <= 24; k++) begin
         load_ir((k % 2) ? 3'b010 : 3'b111, 1'b0, cap);
         for (int i = 0; i < k; i++) go((((k * 13) + (i * 7)) % 5) < 2);
         tms_reset();
         chk("R2 core_hiz cleared by tms reset", core_hiz, 1'b0);
         scan_dr(32, '0, dout);
         chk("R2 idcode reinstated by tms reset", dout[31:0], ID);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule